// File: doc/BRIEF.md
# Dual-Mode FIFO Read Port Controller

This block runs the read side of a synchronous FIFO. It keeps the read pointer and presents it to the storage array as a read address. It also keeps a shadow count of the words the write side has committed, and it owns the output data register. The write side signals each stored word with a one-cycle pulse. That pulse must already be synchronized into the read clock domain. The array must return the word at the presented address combinationally, within the same read-clock cycle.

The read mode is taken from a select input while master reset is held. In standard mode, a word reaches the output register only when the active-low read enable requests it. A low `empty_n` means there is nothing left to request. In fall-through mode, the controller preloads the output register by itself whenever that register holds no unread word. A low `rdy_n` means the register holds a valid word. A read enable pulse consumes that word and, if one is available, brings in the next.

Top module: `fifo_rd_ctl`

## Requirements
- R1: After master reset (`mrst_n` low on a rising edge), `empty_n` is 0, `rdy_n` is 1, `rd_addr` is 0 and `q` is 0.
- R2: The mode is captured from `fwft_sel` only on edges where `mrst_n` is low (1 = fall-through, 0 = standard). Changing `fwft_sel` at other times has no effect.
- R3: In standard mode, a rising edge with `ren_n` low and at least one stored word loads `rd_data` into `q` and advances `rd_addr` by one.
- R4: A rising edge with `ren_n` high never changes `q`, except for the fall-through preload of an empty output register.
- R5: In standard mode, `empty_n` goes low once the last stored word has been read. While it is low, `ren_n` is ignored: `q` and `rd_addr` keep their values.
- R6: A word whose `wr_seen` pulse is sampled on edge k makes `empty_n` go high after edge k+1, and no earlier.
- R7: In fall-through mode, a word written into an empty FIFO with `wr_seen` sampled on edge k appears on `q` after edge k+2. `rdy_n` goes low at the same edge, without any read enable.
- R8: In fall-through mode, each later word needs an edge with `ren_n` low. A read that consumes the last word sets `rdy_n` high and leaves `q` unchanged. Further reads are ignored until a new word arrives.
- R9: In standard mode, `rdy_n` stays 1 at all times.
- R10: `rd_addr` wraps modulo 2^AW. After wrapping, data keeps being returned in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| ren_n | input | 1 | Read enable, active low |
| fwft_sel | input | 1 | Mode select, captured during reset (1 = fall-through) |
| wr_seen | input | 1 | One-cycle pulse per committed write, already in this clock domain |
| rd_addr | output | AW | Read address to the storage array |
| rd_data | input | DW | Array word at `rd_addr`, valid in the same cycle |
| q | output | DW | Output data register |
| empty_n | output | 1 | Low when no stored word remains to be loaded |
| rdy_n | output | 1 | Fall-through mode: low while `q` holds an unread word |

## Verification
The assertions check every cycle for the following. `q` holds steady without a read or a preload. The address moves by at most one step per edge. No address motion occurs while the FIFO is empty in standard mode. `rdy_n` stays high in standard mode, and in fall-through mode a presented word stays presented until it is read. Only the bench scenarios can show the fixed latencies of the empty and ready flags after a write, the data order across back-to-back reads and a pointer wrap, and that the mode input is ignored outside reset. The bench does this by comparing against a queue kept in its own memory model.

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          ren_n,
  input  logic          fwft_sel,
  input  logic          wr_seen,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] q,
  output logic          empty_n,
  output logic          rdy_n
);
  localparam int PW = AW + 1;

  logic          fwft_q, wr_d, held;
  logic [PW-1:0] wptr, rptr;
  logic [DW-1:0] q_r;

  wire avail = (wptr != rptr);
  wire load  = avail && (fwft_q ? (!held || !ren_n) : !ren_n);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      fwft_q <= fwft_sel;
      wr_d   <= 1'b0;
      wptr   <= '0;
      rptr   <= '0;
      q_r    <= '0;
      held   <= 1'b0;
    end else begin
      wr_d <= wr_seen;
      if (wr_d) wptr <= wptr + 1'b1;
      if (load) begin
        q_r  <= rd_data;
        rptr <= rptr + 1'b1;
      end
      held <= fwft_q && (load || (held && ren_n));
    end
  end

  assign rd_addr = rptr[AW-1:0];
  assign q       = q_r;
  assign empty_n = avail;
  assign rdy_n   = fwft_q ? !held : 1'b1;
endmodule

// File: rtl/fifo_rd_ctl_chk.sv
module fifo_rd_ctl_chk #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          mrst_n,
  input logic          ren_n,
  input logic          mode,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] q,
  input logic          empty_n,
  input logic          rdy_n
);
  a_r4_hold_q: assert property (@(posedge clk) disable iff (!mrst_n)
    (ren_n && !(mode && rdy_n)) |=> $stable(q));

  a_r5_empty_ignore: assert property (@(posedge clk) disable iff (!mrst_n)
    (!mode && !empty_n) |=> $stable(rd_addr));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> (rd_addr == $past(rd_addr) || rd_addr == $past(rd_addr) + 1'b1));

  a_r9_std_rdy: assert property (@(posedge clk) disable iff (!mrst_n)
    !mode |-> rdy_n);

  a_r8_keep_ready: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode && !rdy_n && ren_n) |=> !rdy_n);
endmodule

bind fifo_rd_ctl fifo_rd_ctl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .ren_n(ren_n), .mode(fwft_q),
  .rd_addr(rd_addr), .q(q), .empty_n(empty_n), .rdy_n(rdy_n)
);

// File: tb/sim_fifo_rd_ctl.sv
`timescale 1ns/1ps
module sim_fifo_rd_ctl;
  localparam int DW = 36;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, ren_n = 1'b1, fwft_sel = 1'b0, wr_seen = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] q, rd_data;
  logic empty_n, rdy_n;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] exp_q [$];
  int wp = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign rd_data = mem[rd_addr];

  fifo_rd_ctl #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .mrst_n(mrst_n), .ren_n(ren_n), .fwft_sel(fwft_sel),
    .wr_seen(wr_seen), .rd_addr(rd_addr), .rd_data(rd_data), .q(q),
    .empty_n(empty_n), .rdy_n(rdy_n));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic do_reset(bit m);
    mrst_n = 1'b0; fwft_sel = m; ren_n = 1'b1; wr_seen = 1'b0;
    wp = 0; exp_q.delete();
    tick(); tick();
    mrst_n = 1'b1; fwft_sel = ~m;
  endtask

  task automatic do_write(logic [DW-1:0] v);
    mem[wp % (1<<AW)] = v; wp++; exp_q.push_back(v);
    wr_seen = 1'b1; tick(); wr_seen = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 empty_n", empty_n, 0); chk("R1 rdy_n", rdy_n, 1);
    chk("R1 rd_addr", rd_addr, 0); chk("R1 q", q, 0);
  endtask

  task automatic t_std_latency();
    do_reset(1'b0);
    do_write(36'h111);
    chk("R6 empty_n after edge k", empty_n, 0);
    tick();
    chk("R6 empty_n after edge k+1", empty_n, 1);
    chk("R9 rdy_n std", rdy_n, 1);
    repeat (3) tick();
    chk("R4 q holds with ren_n high", q, 0);
    chk("R3 no read without ren", rd_addr, 0);
    ren_n = 1'b0; tick(); ren_n = 1'b1;
    chk("R3 q loaded", q, exp_q.pop_front());
    chk("R3 rd_addr step", rd_addr, 1);
    chk("R5 empty after last", empty_n, 0);
    ren_n = 1'b0; tick(); tick(); ren_n = 1'b1;
    chk("R5 q ignored when empty", q, 36'h111);
    chk("R5 rd_addr ignored when empty", rd_addr, 1);
  endtask

  task automatic t_std_burst();
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) do_write(36'hA00 + i);
    tick();
    ren_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3 burst data", q, exp_q.pop_front());
    end
    ren_n = 1'b1;
    chk("R5 empty after burst", empty_n, 0);
    chk("R2 mode unchanged (std)", rdy_n, 1);
  endtask

  task automatic t_fwft_first();
    do_reset(1'b1);
    chk("R1 rdy_n fwft", rdy_n, 1);
    do_write(36'hF01);
    chk("R7 not ready after k", rdy_n, 1);
    tick();
    chk("R7 not ready after k+1", rdy_n, 1);
    tick();
    chk("R7 ready after k+2", rdy_n, 0);
    chk("R7 q fell through", q, exp_q.pop_front());
    for (int i = 0; i < 3; i++) do_write(36'hF10 + i);
    repeat (3) tick();
    chk("R8 q waits for ren", q, 36'hF01);
    for (int i = 0; i < 3; i++) begin
      ren_n = 1'b0; tick(); ren_n = 1'b1;
      chk("R8 next word", q, exp_q.pop_front());
      chk("R8 ready held", rdy_n, 0);
    end
    ren_n = 1'b0; tick(); ren_n = 1'b1;
    chk("R8 rdy_n high after last read", rdy_n, 1);
    chk("R8 q kept", q, 36'hF12);
    ren_n = 1'b0; tick(); ren_n = 1'b1;
    chk("R8 read ignored when not ready", rd_addr, 4);
    do_write(36'hF20);
    tick(); tick();
    chk("R7 refill after empty", q, exp_q.pop_front());
    chk("R7 refill ready", rdy_n, 0);
  endtask

  task automatic t_wrap();
    do_reset(1'b0);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 10; i++) do_write(36'hC000 + r*16 + i);
      tick();
      ren_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
        tick();
        chk("R10 wrap order", q, exp_q.pop_front());
      end
      ren_n = 1'b1;
    end
    chk("R10 rd_addr wrapped", rd_addr, 30 % (1<<AW));
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    tick();
    t_reset();
    t_std_latency();
    t_std_burst();
    t_fwft_first();
    t_wrap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule